// File: doc/BRIEF.md
# Input Port Packet Buffer Allocator

This block serves one input port of a three-by-three packet router. Packets arrive as a stream of fixed-length words, and a start-of-packet flag marks the first word of each packet. In the cycle that flag is seen, the block checks its four packet slots and picks one of three outcomes. If any slot is free, the packet is written into the lowest-numbered free slot. If no slot is free but at least one slot is being read out by the output side, the block raises a one-cycle wait pulse and the packet is not taken. If every slot is either filling or queued, the block raises a one-cycle error pulse and the packet is dropped.

A stored packet is complete once its twelfth word has been written. At that point the block builds a request record from the slot index, this port's number and the destination port. The destination is carried in the low two bits of the first payload word, which is word 2. If the destination is valid, the record is pushed into a four-entry request queue. If the destination is invalid, no record is made and the slot is freed at once.

The transmit side reads the queue head and pops it. Popping marks that record's slot as being sent. Later the transmit side frees the slot with a release strobe that carries the slot index. A read port exposes the words of any slot.

Top module: `inport_buf_alloc`

## Requirements
- R1: After reset all four slots are free, the request queue is empty (req_valid low), and wait_o and err_o are low.
- R2: When one or more slots are free at a start of packet, the packet goes to the free slot with the lowest index. Neither wait_o nor err_o pulses in this case.
- R3: Word k of a stored packet (k = 0 to 11) can be read at rd_data when rd_buf names its slot and rd_word is k.
- R4: The cycle after the twelfth word is accepted, a record is at the queue tail. Its layout is bit 6 = 1 (valid), bits 5:4 = destination, bits 3:2 = this port's number (IN_PORT), bits 1:0 = slot index.
- R5: A destination value of 3 is invalid. Such a packet produces no record, and its slot is free again for the next packet.
- R6: When no slot is free and at least one slot is being sent, a start of packet gives wait_o high for exactly the following cycle. That packet writes no slot and makes no record.
- R7: When no slot is free and none is being sent, a start of packet gives err_o high for exactly the following cycle. That packet writes no slot and makes no record.
- R8: A req_pop on a non-empty queue marks the head record's slot as being sent. A release frees the named slot only if that slot is being sent; a release of any other slot is ignored.
- R9: Records leave the queue in the order they entered. A pop on an empty queue is ignored, and the queue never holds more records than there are queued slots.
- R10: Words that arrive without a start flag after a packet is complete, or that belong to a packet that was waited or dropped, change no slot and make no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word present on in_data |
| in_sop | input | 1 | Word is the first of a packet |
| in_data | input | 16 | Packet word |
| wait_o | output | 1 | One-cycle pulse: packet refused, a slot will free soon |
| err_o | output | 1 | One-cycle pulse: packet dropped, no slot available |
| req_valid | output | 1 | Request queue not empty |
| req_rec | output | 7 | Record at the queue head |
| req_pop | input | 1 | Remove the head record and mark its slot as sending |
| rel_valid | input | 1 | Release strobe from the output side |
| rel_idx | input | 2 | Slot named by the release |
| rd_buf | input | 2 | Slot selected for reading |
| rd_word | input | 4 | Word selected for reading |
| rd_data | output | 16 | Selected stored word |

## Verification
The assertions assume that every packet is sent as twelve words with no new start flag in the middle. They also assume that releases name only slots the transmit side has popped, and that pops happen only while req_valid is high. Under those conditions the queue occupancy always equals the number of queued slots, and wait and error pulses follow only a start of packet. The stimulus sends whole packets, pops only after reading a valid head, and issues the single out-of-order release on purpose, to show that it is ignored. The stimulus also includes one pop on an empty queue, which the design ignores.

// File: rtl/inport_buf_alloc_pkg.sv
`timescale 1ns/1ps
package inport_buf_alloc_pkg;

   typedef enum logic [1:0] {
      SLOT_FREE   = 2'd0,
      SLOT_FILL   = 2'd1,
      SLOT_QUEUED = 2'd2,
      SLOT_SEND   = 2'd3
   } slot_state_e;

endpackage

// File: rtl/inport_free_pick.sv
`timescale 1ns/1ps
module inport_free_pick #(
   parameter int NUM_BUFS = 4,
   parameter int IDX_W    = 2
) (
   input  logic [NUM_BUFS-1:0] free_vec,
   input  logic [NUM_BUFS-1:0] send_vec,
   output logic                has_free,
   output logic                any_send,
   output logic [IDX_W-1:0]    pick_idx
);

   logic [NUM_BUFS:0]   seen;
   logic [NUM_BUFS-1:0] grant;

   assign seen[0] = 1'b0;

   // priority chain: a slot wins only if no lower slot is free
   for (genvar i = 0; i < NUM_BUFS; i++) begin : g_chain
      assign grant[i]  = free_vec[i] & ~seen[i];
      assign seen[i+1] = seen[i] | free_vec[i];
   end

   always_comb begin
      pick_idx = '0;
      for (int i = 0; i < NUM_BUFS; i++) begin
         if (grant[i]) pick_idx = pick_idx | IDX_W'(i);
      end
   end

   assign has_free = seen[NUM_BUFS];
   assign any_send = |send_vec;

endmodule

// File: rtl/inport_req_fifo.sv
`timescale 1ns/1ps
module inport_req_fifo #(
   parameter int W     = 7,
   parameter int DEPTH = 4,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic             not_empty,
   output logic [CNT_W-1:0] count
);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] rp, wp;
   logic             do_push, do_pop;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign do_push = push && (count != CNT_W'(DEPTH));
   assign do_pop  = pop && (count != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp    <= '0;
         wp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= step(wp);
         if (do_pop)  rp <= step(rp);
         count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= din;
   end

   assign dout      = mem[rp];
   assign not_empty = (count != '0);

endmodule

// File: rtl/inport_pkt_store.sv
`timescale 1ns/1ps
module inport_pkt_store #(
   parameter int NUM_BUFS  = 4,
   parameter int PKT_WORDS = 12,
   parameter int WORD_W    = 16,
   parameter int IDX_W     = 2,
   parameter int CNT_W     = 4,
   localparam int ENTRIES  = NUM_BUFS * PKT_WORDS,
   localparam int ADDR_W   = $clog2(ENTRIES) + 1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  wbuf,
   input  logic [CNT_W-1:0]  wword,
   input  logic [WORD_W-1:0] wdata,
   input  logic [IDX_W-1:0]  rbuf,
   input  logic [CNT_W-1:0]  rword,
   output logic [WORD_W-1:0] rdata
);

   logic [WORD_W-1:0] mem [ENTRIES];
   logic [ADDR_W-1:0] waddr, raddr;

   function automatic logic [ADDR_W-1:0] flat(input logic [IDX_W-1:0] b,
                                              input logic [CNT_W-1:0] w);
      return ADDR_W'(b) * ADDR_W'(PKT_WORDS) + ADDR_W'(w);
   endfunction

   assign waddr = flat(wbuf, wword);
   assign raddr = flat(rbuf, rword);

   always_ff @(posedge clk) begin
      if (we && waddr < ADDR_W'(ENTRIES)) mem[waddr] <= wdata;
   end

   always_comb begin
      if (rword < CNT_W'(PKT_WORDS) && raddr < ADDR_W'(ENTRIES))
         rdata = mem[raddr];
      else
         rdata = '0;
   end

endmodule

// File: rtl/inport_buf_alloc.sv
`timescale 1ns/1ps
module inport_buf_alloc
   import inport_buf_alloc_pkg::*;
#(
   parameter int WORD_W     = 16,
   parameter int PKT_WORDS  = 12,
   parameter int NUM_BUFS   = 4,
   parameter int PORT_W     = 2,
   parameter int IN_PORT    = 1,
   parameter int DEST_WORD  = 2,
   parameter int FIFO_DEPTH = 4,
   localparam int IDX_W     = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1,
   localparam int CNT_W     = $clog2(PKT_WORDS),
   localparam int REC_W     = 1 + 2 * PORT_W + IDX_W,
   localparam int FCNT_W    = $clog2(FIFO_DEPTH + 1),
   localparam int BAD_DEST  = (1 << PORT_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic [WORD_W-1:0] in_data,
   output logic              wait_o,
   output logic              err_o,
   output logic              req_valid,
   output logic [REC_W-1:0]  req_rec,
   input  logic              req_pop,
   input  logic              rel_valid,
   input  logic [IDX_W-1:0]  rel_idx,
   input  logic [IDX_W-1:0]  rd_buf,
   input  logic [CNT_W-1:0]  rd_word,
   output logic [WORD_W-1:0] rd_data
);

   // elaboration-time parameter checks
   if (NUM_BUFS < 2) begin : g_chk_bufs
      $error("NUM_BUFS must be at least 2");
   end
   if (PKT_WORDS < 2) begin : g_chk_words
      $error("PKT_WORDS must be at least 2");
   end
   if (DEST_WORD >= PKT_WORDS) begin : g_chk_dest
      $error("DEST_WORD must index a word inside the packet");
   end
   if (FIFO_DEPTH < NUM_BUFS) begin : g_chk_fifo
      $error("FIFO_DEPTH must cover every slot");
   end
   if (IN_PORT >= BAD_DEST || IN_PORT < 0) begin : g_chk_port
      $error("IN_PORT must be a valid port number");
   end
   if (WORD_W < PORT_W) begin : g_chk_wordw
      $error("WORD_W too narrow for the destination field");
   end

   logic [NUM_BUFS-1:0] free_vec, send_vec, queued_vec;
   logic                has_free, any_send;
   logic [IDX_W-1:0]    pick_idx;

   logic                filling;
   logic [IDX_W-1:0]    cur_idx;
   logic [CNT_W-1:0]    wcnt;
   logic [PORT_W-1:0]   dest_q, dest_eff;

   logic                sop_fire, word_fire, alloc_now, abort_now, complete;
   logic                dest_ok, push, pop_fire;
   logic [IDX_W-1:0]    head_idx;
   logic [REC_W-1:0]    rec_new;
   logic [FCNT_W-1:0]   fifo_cnt;

   logic                mem_we;
   logic [IDX_W-1:0]    mem_buf;
   logic [CNT_W-1:0]    mem_word;

   inport_free_pick #(
      .NUM_BUFS (NUM_BUFS),
      .IDX_W    (IDX_W)
   ) u_pick (
      .free_vec (free_vec),
      .send_vec (send_vec),
      .has_free (has_free),
      .any_send (any_send),
      .pick_idx (pick_idx)
   );

   // stream qualification
   assign sop_fire  = in_valid & in_sop;
   assign word_fire = in_valid & ~in_sop & filling;
   assign alloc_now = sop_fire & has_free;
   assign abort_now = sop_fire & filling;
   assign complete  = word_fire & (wcnt == CNT_W'(PKT_WORDS - 1));

   assign dest_eff = (word_fire && wcnt == CNT_W'(DEST_WORD)) ?
                     in_data[PORT_W-1:0] : dest_q;
   assign dest_ok  = (dest_eff != PORT_W'(BAD_DEST));
   assign push     = complete & dest_ok;
   assign rec_new  = {1'b1, dest_eff, PORT_W'(IN_PORT), cur_idx};
   assign pop_fire = req_pop & req_valid;
   assign head_idx = req_rec[IDX_W-1:0];

   // packet sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         filling <= 1'b0;
         cur_idx <= '0;
         wcnt    <= '0;
         dest_q  <= '0;
         wait_o  <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         wait_o <= 1'b0;
         err_o  <= 1'b0;
         if (sop_fire) begin
            filling <= has_free;
            cur_idx <= pick_idx;
            wcnt    <= CNT_W'(1);
            wait_o  <= ~has_free & any_send;
            err_o   <= ~has_free & ~any_send;
            if (DEST_WORD == 0) dest_q <= in_data[PORT_W-1:0];
         end else if (word_fire) begin
            wcnt <= wcnt + 1'b1;
            if (wcnt == CNT_W'(DEST_WORD)) dest_q <= in_data[PORT_W-1:0];
            if (complete) filling <= 1'b0;
         end
      end
   end

   // per-slot state machines
   for (genvar b = 0; b < NUM_BUFS; b++) begin : g_slot
      slot_state_e st_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_q <= SLOT_FREE;
         end else if (alloc_now && pick_idx == IDX_W'(b)) begin
            st_q <= SLOT_FILL;
         end else if (complete && cur_idx == IDX_W'(b)) begin
            st_q <= dest_ok ? SLOT_QUEUED : SLOT_FREE;
         end else if (abort_now && cur_idx == IDX_W'(b)) begin
            st_q <= SLOT_FREE;
         end else if (pop_fire && head_idx == IDX_W'(b) && st_q == SLOT_QUEUED) begin
            st_q <= SLOT_SEND;
         end else if (rel_valid && rel_idx == IDX_W'(b) && st_q == SLOT_SEND) begin
            st_q <= SLOT_FREE;
         end
      end

      assign free_vec[b]   = (st_q == SLOT_FREE);
      assign send_vec[b]   = (st_q == SLOT_SEND);
      assign queued_vec[b] = (st_q == SLOT_QUEUED);
   end

   // payload storage
   assign mem_we   = alloc_now | word_fire;
   assign mem_buf  = sop_fire ? pick_idx : cur_idx;
   assign mem_word = sop_fire ? '0 : wcnt;

   inport_pkt_store #(
      .NUM_BUFS  (NUM_BUFS),
      .PKT_WORDS (PKT_WORDS),
      .WORD_W    (WORD_W),
      .IDX_W     (IDX_W),
      .CNT_W     (CNT_W)
   ) u_store (
      .clk   (clk),
      .we    (mem_we),
      .wbuf  (mem_buf),
      .wword (mem_word),
      .wdata (in_data),
      .rbuf  (rd_buf),
      .rword (rd_word),
      .rdata (rd_data)
   );

   // request queue
   inport_req_fifo #(
      .W     (REC_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .din       (rec_new),
      .pop       (req_pop),
      .dout      (req_rec),
      .not_empty (req_valid),
      .count     (fifo_cnt)
   );

endmodule

// File: rtl/inport_buf_alloc_chk.sv
`timescale 1ns/1ps
module inport_buf_alloc_chk #(
   parameter int NUM_BUFS = 4,
   parameter int PORT_W   = 2,
   parameter int IDX_W    = 2,
   parameter int REC_W    = 7,
   parameter int FCNT_W   = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                in_valid,
   input logic                in_sop,
   input logic                wait_o,
   input logic                err_o,
   input logic                req_valid,
   input logic [REC_W-1:0]    req_rec,
   input logic                rel_valid,
   input logic [IDX_W-1:0]    rel_idx,
   input logic [NUM_BUFS-1:0] free_vec,
   input logic [NUM_BUFS-1:0] send_vec,
   input logic [NUM_BUFS-1:0] queued_vec,
   input logic [FCNT_W-1:0]   fifo_cnt
);

   localparam logic [PORT_W-1:0] BAD = '1;

   a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      !(wait_o && err_o));

   a_r6_wait_after_sop: assert property (@(posedge clk) disable iff (!rst_n)
      wait_o |-> $past(in_valid && in_sop));

   a_r7_err_after_sop: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(in_valid && in_sop));

   a_r2_store_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sop && free_vec != '0) |=> (!wait_o && !err_o));

   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      32'(fifo_cnt) == $countones(queued_vec));

   a_r5_record_dest_ok: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_rec[REC_W-1] && req_rec[REC_W-2 -: PORT_W] != BAD));

   a_r8_release_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (rel_valid && send_vec[rel_idx]) |=> free_vec[$past(rel_idx)]);

endmodule

bind inport_buf_alloc inport_buf_alloc_chk #(
   .NUM_BUFS (NUM_BUFS),
   .PORT_W   (PORT_W),
   .IDX_W    (IDX_W),
   .REC_W    (REC_W),
   .FCNT_W   (FCNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_sop     (in_sop),
   .wait_o     (wait_o),
   .err_o      (err_o),
   .req_valid  (req_valid),
   .req_rec    (req_rec),
   .rel_valid  (rel_valid),
   .rel_idx    (rel_idx),
   .free_vec   (free_vec),
   .send_vec   (send_vec),
   .queued_vec (queued_vec),
   .fifo_cnt   (fifo_cnt)
);

// File: tb/inport_buf_alloc_test.sv
`timescale 1ns/1ps
module inport_buf_alloc_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_sop = 1'b0;
   logic [15:0] in_data = '0;
   logic        wait_o, err_o, req_valid;
   logic [6:0]  req_rec;
   logic        req_pop = 1'b0;
   logic        rel_valid = 1'b0;
   logic [1:0]  rel_idx = '0;
   logic [1:0]  rd_buf = '0;
   logic [3:0]  rd_word = '0;
   logic [15:0] rd_data;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   inport_buf_alloc uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sop    (in_sop),
      .in_data   (in_data),
      .wait_o    (wait_o),
      .err_o     (err_o),
      .req_valid (req_valid),
      .req_rec   (req_rec),
      .req_pop   (req_pop),
      .rel_valid (rel_valid),
      .rel_idx   (rel_idx),
      .rd_buf    (rd_buf),
      .rd_word   (rd_word),
      .rd_data   (rd_data)
   );

   // this port is number 1; record = 64 + dest*16 + 4 + slot
   function automatic int rec_of(int d, int s);
      return 64 + d * 16 + 4 + s;
   endfunction

   function automatic logic [15:0] pkt_word(int t, int k, int d);
      return {t[7:0], k[3:0], 2'b00, (k == 2) ? d[1:0] : 2'b00};
   endfunction

   task automatic check_eq(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic send_pkt(input int t, input int d, output logic w, output logic e);
      w = 1'b0;
      e = 1'b0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (k == 1) begin
            w = wait_o;
            e = err_o;
         end
         in_valid = 1'b1;
         in_sop   = (k == 0);
         in_data  = pkt_word(t, k, d);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
   endtask

   task automatic check_buf(input string req, input int s, input int t, input int d);
      int bad;
      bad = 0;
      for (int k = 0; k < 12; k++) begin
         rd_buf  = s[1:0];
         rd_word = k[3:0];
         #0.1;
         if (rd_data != pkt_word(t, k, d)) bad++;
      end
      check_eq(req, bad, 0);
   endtask

   task automatic pop_head();
      @(negedge clk);
      req_pop = 1'b1;
      @(negedge clk);
      req_pop = 1'b0;
   endtask

   task automatic release_slot(input int s);
      @(negedge clk);
      rel_valid = 1'b1;
      rel_idx   = s[1:0];
      @(negedge clk);
      rel_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic w, e;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check_eq("R1 req_valid", 32'(req_valid), 0);
      check_eq("R1 wait_o", 32'(wait_o), 0);
      check_eq("R1 err_o", 32'(err_o), 0);

      // A -> slot 0 (R2, R4, R3)
      send_pkt(1, 1, w, e);
      check_eq("R2 no pulse", 32'({w, e}), 0);
      check_eq("R4 record A", 32'(req_rec), rec_of(1, 0));
      check_eq("R4 valid", 32'(req_valid), 1);
      check_buf("R3 slot0 A", 0, 1, 1);

      // B -> slot 1
      send_pkt(2, 2, w, e);
      check_buf("R2 slot1 B", 1, 2, 2);
      check_eq("R9 head still A", 32'(req_rec), rec_of(1, 0));

      // C has invalid dest, slot 2 returns to free (R5)
      send_pkt(3, 3, w, e);
      check_eq("R5 no pulse", 32'({w, e}), 0);
      send_pkt(4, 0, w, e);
      check_buf("R5 slot2 reused", 2, 4, 0);

      // E -> slot 3
      send_pkt(5, 1, w, e);
      check_buf("R2 slot3 E", 3, 5, 1);

      // F: all queued, none sending -> error (R7)
      send_pkt(6, 2, w, e);
      check_eq("R7 err", 32'(e), 1);
      check_eq("R7 no wait", 32'(w), 0);
      check_buf("R7 slot3 kept", 3, 5, 1);
      check_eq("R7 head", 32'(req_rec), rec_of(1, 0));

      // pop A: slot 0 sending, head becomes B (R8, R9)
      pop_head();
      check_eq("R9 head B", 32'(req_rec), rec_of(2, 1));

      // G: no free, slot 0 sending -> wait (R6)
      send_pkt(7, 1, w, e);
      check_eq("R6 wait", 32'(w), 1);
      check_eq("R6 no err", 32'(e), 0);
      check_buf("R6 slot0 kept", 0, 1, 1);
      check_eq("R6 head", 32'(req_rec), rec_of(2, 1));

      // release of queued slot 1 is ignored (R8)
      release_slot(1);
      send_pkt(8, 0, w, e);
      check_eq("R8 ignored release", 32'(w), 1);

      // release slot 0 then I -> slot 0 (R8)
      release_slot(0);
      send_pkt(9, 2, w, e);
      check_eq("R8 stored", 32'({w, e}), 0);
      check_buf("R8 slot0 I", 0, 9, 2);

      // stray words without a start flag (R10)
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_sop   = 1'b0;
         in_data  = 16'hFFFF;
      end
      @(negedge clk);
      in_valid = 1'b0;
      check_buf("R10 slot0 unchanged", 0, 9, 2);

      // drain in order (R9)
      check_eq("R9 order B", 32'(req_rec), rec_of(2, 1));
      pop_head();
      check_eq("R9 order D", 32'(req_rec), rec_of(0, 2));
      pop_head();
      check_eq("R9 order E", 32'(req_rec), rec_of(1, 3));
      pop_head();
      check_eq("R9 order I", 32'(req_rec), rec_of(2, 0));
      pop_head();
      check_eq("R10 no extra record", 32'(req_valid), 0);
      pop_head();
      check_eq("R9 empty pop ignored", 32'(req_valid), 0);

      for (int s = 0; s < 4; s++) release_slot(s);

      // sweep over every destination value, always into slot 0
      for (int d = 0; d < 4; d++) begin
         send_pkt(16 + d, d, w, e);
         check_buf("R3 sweep", 0, 16 + d, d);
         if (d == 3) begin
            check_eq("R5 sweep no record", 32'(req_valid), 0);
         end else begin
            check_eq("R4 sweep record", 32'(req_rec), rec_of(d, 0));
            pop_head();
            release_slot(0);
         end
      end
      send_pkt(30, 1, w, e);
      check_eq("R5 slot0 after invalid", 32'(req_rec), rec_of(1, 0));

      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule